// File: doc/BRIEF.md
# Prediction-Based Sample Error Detector and Corrector

This block sits behind a digital filter whose arithmetic may produce occasional large errors, for example when it runs with timing margin removed. A short linear forward predictor estimates each incoming sample from the samples that came before it, using coefficients that are set through an input bus. The residual between each received sample and its estimate is kept in a short window.

Once NP further samples have arrived, the block decides whether an earlier sample was corrupted. It weights the residual of that sample and the NP residuals that follow it by the vector [1, -hp(1), ..., -hp(NP)]. If the magnitude of this sum is strictly above a programmable threshold, the sample is treated as faulty and its predicted value is sent out in its place. Otherwise the received value is passed through unchanged.

Each output comes with a valid strobe and an error flag for that sample. The output stream is therefore the input stream delayed by NP accepted samples. Correct operation assumes at most one corrupted sample in any span of 2*NP samples.

Top module: `ant_corrector`

## Requirements
- R1: The prediction of sample n is computed as follows. Take the sum over k=1..NP of hp(k)*x(n-k). Add 2^(FRAC-1) to it, shift it arithmetically right by FRAC, and saturate it to the signed DW-bit range. hp(k) is a signed CW-bit value with FRAC fraction bits, located at coef_i[(k-1)*CW +: CW]. Samples before the first accepted one count as zero.
- R2: The residual of sample n is e(n) = x(n) - pred(n). It is kept at DW+1 bits with no loss.
- R3: The decision statistic of sample m is s(m) = e(m) - rnd(sum over k=1..NP of hp(k)*e(m+k)). rnd adds 2^(FRAC-1) and then shifts arithmetically right by FRAC, with no saturation.
- R4: Sample m is flagged when |s(m)| is strictly greater than thresh_i, which is read as unsigned. A statistic equal to the threshold is not flagged.
- R5: The output sample is pred(m) when sample m is flagged, and x(m) when it is not.
- R6: The output for sample m is valid during exactly the clock cycle after the edge that accepts sample m+NP. The first NP accepted samples produce no output, and out_valid_o is never high in the cycle after an edge with in_valid_i low.
- R7: out_err_o is high only together with out_valid_o, and it marks the sample being presented in that cycle.
- R8: A cycle with in_valid_i low leaves out_sample_o and all of the history unchanged.
- R9: After reset, out_valid_o, out_err_o and out_sample_o are zero, and the history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input sample strobe |
| in_sample_i | input | DW | Received filter output, signed |
| coef_i | input | NP*CW | Predictor coefficients hp(1..NP), signed fixed point with FRAC fraction bits |
| thresh_i | input | TW | Detection threshold, unsigned |
| out_valid_o | output | 1 | Output sample strobe |
| out_sample_o | output | DW | Corrected sample, signed |
| out_err_o | output | 1 | The presented sample was flagged and replaced |

## Verification
Two situations are hard to reach from the ports: a decision statistic that lands exactly on the threshold, and a corrupted sample whose replacement has to be checked against the value it should have had. The bench first runs a clean ramp with a single injected spike through its own arithmetic model and reads off the statistic of the spike sample. It then replays the same stream with the threshold set to that exact magnitude and to one below it. Further sweeps cover three coefficient sets, three signal shapes, spikes of either sign and streams with idle gaps, and every output is compared with the model.

// File: rtl/ant_pkg.sv
package ant_pkg;

  // round half up by 2^frac, then clamp to an ow-bit signed range
  function automatic logic signed [63:0] rnd_sat(input logic signed [63:0] acc,
                                                 input int unsigned frac,
                                                 input int unsigned ow);
    logic signed [63:0] r, hi, lo;
    r  = (acc + (64'sd1 <<< (frac - 1))) >>> frac;
    hi = (64'sd1 <<< (ow - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/ant_predictor.sv
module ant_predictor
  import ant_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 12,
  parameter int NP   = 3
) (
  input  logic signed [DW-1:0] hist_i [NP],
  input  logic signed [CW-1:0] coef_i [NP],
  output logic signed [DW-1:0] pred_o
);

  logic signed [63:0] prod [NP];
  logic signed [63:0] acc;

  for (genvar k = 0; k < NP; k++) begin : g_tap
    assign prod[k] = 64'(hist_i[k]) * 64'(coef_i[k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NP; k++) acc = acc + prod[k];
  end

  assign pred_o = DW'(rnd_sat(acc, FRAC, DW));

endmodule

// File: rtl/ant_detector.sv
module ant_detector
  import ant_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 12,
  parameter int NP   = 3,
  parameter int TW   = DW + 2,
  localparam int EW  = DW + 1
) (
  input  logic signed [EW-1:0] win_i  [NP+1],  // win_i[j] = e(m+j)
  input  logic signed [CW-1:0] coef_i [NP],
  input  logic        [TW-1:0] thr_i,
  output logic                 flag_o
);

  logic signed [63:0] prod [NP];
  logic signed [63:0] acc, stat, mag;

  for (genvar k = 0; k < NP; k++) begin : g_tap
    assign prod[k] = 64'(win_i[k+1]) * 64'(coef_i[k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NP; k++) acc = acc + prod[k];
    stat = 64'(win_i[0]) - rnd_sat(acc, FRAC, 63);
    mag  = (stat < 0) ? -stat : stat;
  end

  assign flag_o = mag > 64'(thr_i);

endmodule

// File: rtl/ant_corrector.sv
module ant_corrector
  import ant_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 12,
  parameter int NP   = 3,
  parameter int TW   = DW + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    in_sample_i,
  input  logic [NP*CW-1:0] coef_i,
  input  logic [TW-1:0]    thresh_i,
  output logic             out_valid_o,
  output logic [DW-1:0]    out_sample_o,
  output logic             out_err_o
);

  localparam int EW  = DW + 1;
  localparam int FCW = $clog2(NP + 1) + 1;

  logic signed [CW-1:0] coef [NP];
  logic signed [DW-1:0] x_q  [NP];   // x_q[i] = x(n-1-i)
  logic signed [DW-1:0] p_q  [NP];
  logic signed [EW-1:0] e_q  [NP];
  logic signed [EW-1:0] win  [NP+1];
  logic        [FCW-1:0] fill_q;
  logic signed [DW-1:0] x_n, pred_n;
  logic signed [EW-1:0] e_n;
  logic                 full, flag;
  logic                 out_valid_q, out_err_q;
  logic        [DW-1:0] out_q;

  for (genvar g = 0; g < NP; g++) begin : g_coef
    assign coef[g] = coef_i[g*CW +: CW];
  end

  assign x_n = in_sample_i;

  ant_predictor #(.DW(DW), .CW(CW), .FRAC(FRAC), .NP(NP)) u_pred (
    .hist_i (x_q),
    .coef_i (coef),
    .pred_o (pred_n)
  );

  assign e_n = EW'(x_n) - EW'(pred_n);

  // window for m = n-NP: oldest residual first, newest last
  for (genvar j = 0; j < NP; j++) begin : g_win
    assign win[j] = e_q[NP-1-j];
  end
  assign win[NP] = e_n;

  ant_detector #(.DW(DW), .CW(CW), .FRAC(FRAC), .NP(NP), .TW(TW)) u_det (
    .win_i  (win),
    .coef_i (coef),
    .thr_i  (thresh_i),
    .flag_o (flag)
  );

  assign full = (fill_q == FCW'(NP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NP; i++) begin
        x_q[i] <= '0;
        p_q[i] <= '0;
        e_q[i] <= '0;
      end
      fill_q      <= '0;
      out_valid_q <= 1'b0;
      out_err_q   <= 1'b0;
      out_q       <= '0;
    end else begin
      out_valid_q <= in_valid_i && full;
      out_err_q   <= in_valid_i && full && flag;
      if (in_valid_i) begin
        x_q[0] <= x_n;
        p_q[0] <= pred_n;
        e_q[0] <= e_n;
        for (int i = 1; i < NP; i++) begin
          x_q[i] <= x_q[i-1];
          p_q[i] <= p_q[i-1];
          e_q[i] <= e_q[i-1];
        end
        if (!full) fill_q <= fill_q + 1'b1;
        if (full)  out_q  <= flag ? p_q[NP-1] : x_q[NP-1];
      end
    end
  end

  assign out_valid_o  = out_valid_q;
  assign out_err_o    = out_err_q;
  assign out_sample_o = out_q;

endmodule

// File: rtl/ant_corrector_chk.sv
module ant_corrector_chk #(
  parameter int DW = 16,
  parameter int NP = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [DW-1:0] in_sample_i,
  input logic          out_valid_o,
  input logic [DW-1:0] out_sample_o,
  input logic          out_err_o
);

  localparam int SCW = $clog2(NP + 2) + 1;

  logic [DW-1:0]  sh_q [NP+1];   // raw samples, sh_q[0] newest
  logic [SCW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= NP; i++) sh_q[i] <= '0;
      seen_q <= '0;
    end else if (in_valid_i) begin
      sh_q[0] <= in_sample_i;
      for (int i = 1; i <= NP; i++) sh_q[i] <= sh_q[i-1];
      if (seen_q != SCW'(NP + 1)) seen_q <= seen_q + 1'b1;
    end
  end

  // R7
  err_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_err_o |-> out_valid_o);

  // R6
  valid_after_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));

  // R6
  warmup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> seen_q == SCW'(NP + 1));

  // R5
  passthrough_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_err_o) |-> out_sample_o == sh_q[NP]);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_sample_o));

endmodule

bind ant_corrector ant_corrector_chk #(.DW(DW), .NP(NP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_sample_i  (in_sample_i),
  .out_valid_o  (out_valid_o),
  .out_sample_o (out_sample_o),
  .out_err_o    (out_err_o)
);

// File: tb/test_ant_corrector.sv
`timescale 1ns/1ps
module test_ant_corrector;

  localparam int DW = 16, CW = 16, FRAC = 12, NP = 3, TW = DW + 2;
  localparam int NS = 40;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [DW-1:0]    in_sample_i = '0;
  logic [NP*CW-1:0] coef_i = '0;
  logic [TW-1:0]    thresh_i = '0;
  logic             out_valid_o;
  logic [DW-1:0]    out_sample_o;
  logic             out_err_o;

  ant_corrector #(.DW(DW), .CW(CW), .FRAC(FRAC), .NP(NP), .TW(TW)) i_ant_corrector (.*);

  always #5 clk_i = ~clk_i;

  int     n_chk = 0, n_bad = 0;
  bit     done = 1'b0;
  int     h [NP];
  int     xs [NS], clean [NS], pr [NS], ee [NS], ov [NS];
  longint st [NS];
  bit     fl [NS];
  int     got_o [NS];
  bit     got_f [NS];
  int     thr_cur;
  bit     pend_v;
  int     pend_idx;
  int     last_out;

  function automatic longint rnd(longint v);
    return (v + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
  endfunction

  function automatic int clampw(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_model();
    for (int i = 0; i < NS; i++) begin
      longint acc = 0;
      for (int k = 1; k <= NP; k++) if (i - k >= 0) acc += longint'(h[k-1]) * xs[i-k];
      pr[i] = clampw(rnd(acc));
      ee[i] = xs[i] - pr[i];
    end
    for (int m = 0; m + NP < NS; m++) begin
      longint acc = 0;
      longint a;
      for (int k = 1; k <= NP; k++) acc += longint'(h[k-1]) * ee[m+k];
      st[m] = ee[m] - rnd(acc);
      a = (st[m] < 0) ? -st[m] : st[m];
      fl[m] = a > thr_cur;
      ov[m] = fl[m] ? pr[m] : xs[m];
    end
  endtask

  task automatic set_stream(input int cset, input int mode, input int sp, input int amp);
    case (cset)
      0: begin h[0] = 8192;  h[1] = -4096;  h[2] = 0;    end
      1: begin h[0] = 12288; h[1] = -12288; h[2] = 4096; end
      default: begin h[0] = 3072; h[1] = 1024; h[2] = 0; end
    endcase
    for (int i = 0; i < NS; i++) begin
      case (mode)
        0: clean[i] = 100 + 37 * i;
        1: clean[i] = ((i * i * 8) >>> 2) - 500;
        default: clean[i] = ((i * 7919) % 601) - 300;
      endcase
      xs[i] = clean[i];
    end
    if (sp >= 0) xs[sp] = clampw(longint'(xs[sp]) + amp);
  endtask

  // one cycle: check what the previous edge produced, then drive the next input
  task automatic cyc(input bit v, input int idx);
    @(negedge clk_i);
    check(out_valid_o == pend_v, "R6 out_valid", out_valid_o, pend_v);
    if (out_err_o) check(out_valid_o, "R7 err without valid", out_valid_o, 1);
    if (pend_v) begin
      got_o[pend_idx] = int'($signed(out_sample_o));
      got_f[pend_idx] = out_err_o;
      check(got_o[pend_idx] == ov[pend_idx], "R1 R2 R5 sample", got_o[pend_idx], ov[pend_idx]);
      check(got_f[pend_idx] == fl[pend_idx], "R3 R4 flag", got_f[pend_idx], fl[pend_idx]);
      last_out = got_o[pend_idx];
    end else begin
      check(int'($signed(out_sample_o)) == last_out, "R8 idle hold",
            int'($signed(out_sample_o)), last_out);
    end
    in_valid_i  = v;
    in_sample_i = DW'(xs[idx]);
    pend_v      = v && (idx >= NP);
    pend_idx    = idx - NP;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check(!out_valid_o && !out_err_o && out_sample_o == '0, "R9 reset",
          {out_valid_o, out_err_o, out_sample_o}, 0);
    rst_ni = 1'b1;
    pend_v = 1'b0;
    pend_idx = 0;
    last_out = 0;
  endtask

  task automatic run(input int cset, input int mode, input int sp, input int amp,
                     input int thr, input bit gap);
    set_stream(cset, mode, sp, amp);
    thr_cur = thr;
    build_model();
    coef_i   = {CW'(h[2]), CW'(h[1]), CW'(h[0])};
    thresh_i = TW'(thr);
    do_reset();
    for (int i = 0; i < NS; i++) begin
      cyc(1'b1, i);
      if (gap && (i % 3 == 1)) cyc(1'b0, 0);
      if (gap && (i % 7 == 4)) cyc(1'b0, 0);
    end
    cyc(1'b0, 0);
    cyc(1'b0, 0);
  endtask

  initial begin
    int s20;
    // ramp, exact linear extrapolation, spike at 20
    run(0, 0, 20, 3000, 200, 1'b0);
    check(got_f[20] == 1'b1, "R4 spike flagged", got_f[20], 1);
    check(got_o[20] == clean[20], "R5 spike replaced by prediction", got_o[20], clean[20]);
    check(got_f[10] == 1'b0, "R5 clean sample passed", got_f[10], 0);
    // threshold boundary on the spike statistic
    s20 = int'((st[20] < 0) ? -st[20] : st[20]);
    run(0, 0, 20, 3000, s20, 1'b1);
    check(got_f[20] == 1'b0, "R4 equal to threshold not flagged", got_f[20], 0);
    check(got_o[20] == xs[20], "R5 unflagged passes raw", got_o[20], xs[20]);
    run(0, 0, 20, 3000, s20 - 1, 1'b0);
    check(got_f[20] == 1'b1, "R4 one above threshold flagged", got_f[20], 1);
    // sweep coefficient sets, signal shapes, spike amplitudes, gaps
    for (int c = 0; c < 3; c++)
      for (int md = 0; md < 3; md++)
        for (int a = 0; a < 3; a++)
          run(c, md, 15 + a, (a == 0) ? 0 : ((a == 1) ? 500 : -2500), 300, 1'((c + md) % 2));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule